// File: doc/BRIEF.md
# Demand-Service Ratio Thread Ranker

This block orders the hardware threads that share a DRAM controller by how poorly they are being served compared with what they ask for. Each thread drives three single-cycle event pulses: one per retired instruction, one per last-level cache miss and one per memory request that the controller has completed. The block counts these events over a fixed window of `INTERVAL` clock cycles. At the end of each window it freezes the counts and builds a key for each thread. Demand is the thread's miss rate. The ratio is that demand divided by the number of requests the thread was served.

A sequential odd-even transposition network sorts the keys in `N_THREADS` cycles. Each comparison uses cross-multiplication, so no divider is needed. When the sort is done, the block publishes a new rank order and the top thread ID and pulses a done strobe. Both outputs then hold until the next window's result is ready. The scheduler that consumes the rank decides on its own when to act on it. This block never forces a change in which thread is being served.

Top module: `dsr_thread_ranker`

## Requirements
- R1: A window lasts `INTERVAL` cycles. The first window starts in the first cycle after reset is released. Pulses in the first `INTERVAL-1` cycles of a window are ranked at the end of that window.
- R2: A thread's demand is misses divided by instructions. The factor of one thousand is the same for every thread and cancels. A thread with zero instructions has demand zero.
- R3: A thread's ratio is its demand divided by its served count. A served count of zero gives the largest possible ratio, whatever the demand.
- R4: Slot k of `order_o` (bits `k*IDW +: IDW`) holds the thread ID at rank k, with slot 0 the highest ratio. Ratios are in descending order. Equal ratios, including several zero-service threads, put the lower thread ID first. The slots always form a permutation of the IDs.
- R5: Every counter restarts at each window boundary. A pulse in the last cycle of a window counts toward the next window.
- R6: Each counter saturates at `2**CNT_W-1` and does not wrap.
- R7: `done_o` is high for exactly one cycle: the cycle whose window position is `N_THREADS`, i.e. the `N_THREADS+1`-th cycle of the window after the one that was ranked.
- R8: `order_o` and `top_id_o` change only in the cycle where `done_o` is high. `top_id_o` always equals slot 0 of `order_o`.
- R9: During and after reset, `order_o` holds the identity order (slot k = k), `top_id_o` is 0 and `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_pulse_i | input | N_THREADS | Per-thread retired-instruction pulse |
| miss_pulse_i | input | N_THREADS | Per-thread last-level cache miss pulse |
| serv_pulse_i | input | N_THREADS | Per-thread served-request pulse |
| order_o | output | N_THREADS*IDW | Thread IDs in rank order, slot 0 highest |
| top_id_o | output | IDW | ID of the highest-ranked thread |
| done_o | output | 1 | One-cycle strobe when a new order is published |

## Verification
The bench covers several cases. It checks equal ratios across all threads, where a design with wrong tie handling would scramble IDs that should stay in order. It checks threads with zero service or zero instructions, which a careless cross-multiply would rank as ratio zero or as a tie. It drives counts past the counter limit, where a wrapping counter would drop a thread below one of equal true demand. It places a service pulse exactly in the boundary cycle, where a design that charged the pulse to the closing window would move thread 0 to last place. It also checks the placement of the done strobe and that the outputs hold between strobes.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  typedef enum logic {
    SRT_IDLE = 1'b0,
    SRT_RUN  = 1'b1
  } srt_state_e;
endpackage

// File: rtl/dsr_interval_timer.sv
module dsr_interval_timer #(
  parameter int unsigned INTERVAL = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r1_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/dsr_event_counter.sv
module dsr_event_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pulse_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (tick_i)               cnt_q <= {{(CNT_W-1){1'b0}}, pulse_i}; // boundary pulse goes to new window
    else if (pulse_i && ~&cnt_q)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r6_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && pulse_i && (&cnt_q)) |=> (&cnt_q));
  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (cnt_q == {{(CNT_W-1){1'b0}}, $past(pulse_i)}));
endmodule

// File: rtl/dsr_rank_cmp.sv
module dsr_rank_cmp #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned IDW   = 3
) (
  input  logic               a_inf_i,
  input  logic [CNT_W-1:0]   a_num_i,
  input  logic [2*CNT_W-1:0] a_den_i,
  input  logic [IDW-1:0]     a_id_i,
  input  logic               b_inf_i,
  input  logic [CNT_W-1:0]   b_num_i,
  input  logic [2*CNT_W-1:0] b_den_i,
  input  logic [IDW-1:0]     b_id_i,
  output logic               a_first_o
);
  localparam int unsigned PW = 3 * CNT_W;

  logic [PW-1:0] lhs, rhs;
  logic          id_lo;

  // a/b_den vs b/a_den without a divider
  assign lhs   = {{(2*CNT_W){1'b0}}, a_num_i} * {{CNT_W{1'b0}}, b_den_i};
  assign rhs   = {{(2*CNT_W){1'b0}}, b_num_i} * {{CNT_W{1'b0}}, a_den_i};
  assign id_lo = (a_id_i < b_id_i);

  always_comb begin
    if (a_inf_i && b_inf_i)      a_first_o = id_lo;
    else if (a_inf_i)            a_first_o = 1'b1;
    else if (b_inf_i)            a_first_o = 1'b0;
    else if (lhs != rhs)         a_first_o = (lhs > rhs);
    else                         a_first_o = id_lo;
  end
endmodule

// File: rtl/dsr_sorter.sv
module dsr_sorter
  import dsr_pkg::*;
#(
  parameter int unsigned N_THREADS = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned IDW       = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              load_i,
  input  logic [N_THREADS-1:0][CNT_W-1:0]   instr_cnt_i,
  input  logic [N_THREADS-1:0][CNT_W-1:0]   miss_cnt_i,
  input  logic [N_THREADS-1:0][CNT_W-1:0]   serv_cnt_i,
  output logic [N_THREADS-1:0][IDW-1:0]     order_o,
  output logic                              done_o
);
  localparam logic [IDW-1:0] LAST_PH = IDW'(N_THREADS - 1);

  typedef struct packed {
    logic               inf;
    logic [CNT_W-1:0]   num;
    logic [2*CNT_W-1:0] den;
    logic [IDW-1:0]     id;
  } ent_t;

  ent_t ent_q    [N_THREADS];
  ent_t ent_nxt  [N_THREADS];
  ent_t ent_load [N_THREADS];

  srt_state_e              state_q;
  logic [IDW-1:0]          phase_q;
  logic [N_THREADS-1:0]    swap;
  logic [N_THREADS-1:0][IDW-1:0] order_q;
  logic                    done_q;

  // key build: zero instructions -> demand 0, zero service -> max ratio
  always_comb begin
    for (int t = 0; t < N_THREADS; t++) begin
      ent_load[t].inf = (serv_cnt_i[t] == '0);
      ent_load[t].id  = IDW'(t);
      if (instr_cnt_i[t] == '0) begin
        ent_load[t].num = '0;
        ent_load[t].den = {{(2*CNT_W-1){1'b0}}, 1'b1};
      end else begin
        ent_load[t].num = miss_cnt_i[t];
        ent_load[t].den = {{CNT_W{1'b0}}, instr_cnt_i[t]} * {{CNT_W{1'b0}}, serv_cnt_i[t]};
      end
    end
  end

  assign swap[N_THREADS-1] = 1'b0;

  generate
    for (genvar i = 0; i < N_THREADS - 1; i++) begin : g_cmp
      dsr_rank_cmp #(.CNT_W(CNT_W), .IDW(IDW)) u_cmp (
        .a_inf_i   (ent_q[i+1].inf),
        .a_num_i   (ent_q[i+1].num),
        .a_den_i   (ent_q[i+1].den),
        .a_id_i    (ent_q[i+1].id),
        .b_inf_i   (ent_q[i].inf),
        .b_num_i   (ent_q[i].num),
        .b_den_i   (ent_q[i].den),
        .b_id_i    (ent_q[i].id),
        .a_first_o (swap[i])
      );
    end
  endgenerate

  // odd-even transposition: even phases pair (0,1),(2,3)..., odd phases (1,2),(3,4)...
  always_comb begin
    for (int k = 0; k < N_THREADS; k++) ent_nxt[k] = ent_q[k];
    for (int i = 0; i < N_THREADS - 1; i++) begin
      if (swap[i] && (i[0] == phase_q[0])) begin
        ent_nxt[i]   = ent_q[i+1];
        ent_nxt[i+1] = ent_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRT_IDLE;
      phase_q <= '0;
      done_q  <= 1'b0;
      for (int k = 0; k < N_THREADS; k++) begin
        ent_q[k]   <= '0;
        order_q[k] <= IDW'(k);
      end
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        state_q <= SRT_RUN;
        phase_q <= '0;
        for (int k = 0; k < N_THREADS; k++) ent_q[k] <= ent_load[k];
      end else if (state_q == SRT_RUN) begin
        for (int k = 0; k < N_THREADS; k++) ent_q[k] <= ent_nxt[k];
        if (phase_q == LAST_PH) begin
          state_q <= SRT_IDLE;
          done_q  <= 1'b1;
          for (int k = 0; k < N_THREADS; k++) order_q[k] <= ent_nxt[k].id;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign order_o = order_q;
  assign done_o  = done_q;

  logic [N_THREADS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < N_THREADS; k++) seen[order_q[k]] = 1'b1;
  end

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (order_o != $past(order_o)) |-> done_o);
  a_r1_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (state_q == SRT_IDLE));
  a_r4_permutation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(seen) == N_THREADS));
endmodule

// File: rtl/dsr_thread_ranker.sv
module dsr_thread_ranker #(
  parameter int unsigned N_THREADS = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned INTERVAL  = 1024,
  localparam int unsigned IDW      = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_THREADS-1:0]     instr_pulse_i,
  input  logic [N_THREADS-1:0]     miss_pulse_i,
  input  logic [N_THREADS-1:0]     serv_pulse_i,
  output logic [N_THREADS*IDW-1:0] order_o,
  output logic [IDW-1:0]           top_id_o,
  output logic                     done_o
);
  logic tick;
  logic [N_THREADS-1:0][CNT_W-1:0] instr_cnt, miss_cnt, serv_cnt;
  logic [N_THREADS-1:0][IDW-1:0]   order;

  dsr_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  generate
    for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
      dsr_event_counter #(.CNT_W(CNT_W)) u_instr (
        .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick),
        .pulse_i (instr_pulse_i[t]), .cnt_o (instr_cnt[t])
      );
      dsr_event_counter #(.CNT_W(CNT_W)) u_miss (
        .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick),
        .pulse_i (miss_pulse_i[t]), .cnt_o (miss_cnt[t])
      );
      dsr_event_counter #(.CNT_W(CNT_W)) u_serv (
        .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick),
        .pulse_i (serv_pulse_i[t]), .cnt_o (serv_cnt[t])
      );
    end
  endgenerate

  dsr_sorter #(.N_THREADS(N_THREADS), .CNT_W(CNT_W), .IDW(IDW)) u_sort (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (tick),
    .instr_cnt_i (instr_cnt),
    .miss_cnt_i  (miss_cnt),
    .serv_cnt_i  (serv_cnt),
    .order_o     (order),
    .done_o      (done_o)
  );

  assign order_o  = order;
  assign top_id_o = order[0];

  a_r8_top_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(top_id_o));
endmodule

// File: tb/dsr_thread_ranker_test.sv
`timescale 1ns/1ps
module dsr_thread_ranker_test;
  localparam int N    = 8;
  localparam int CW   = 6;
  localparam int INTV = 128;
  localparam int IDW  = 3;
  localparam int NV   = 7;
  localparam int MAXC = 63;

  // per thread: {instr, miss, serv} pulse counts, 8 bits each
  localparam logic [23:0] VEC [NV][N] = '{
    '{24'h140A05, 24'h140A05, 24'h140A05, 24'h140A05, 24'h140A05, 24'h140A05, 24'h140A05, 24'h140A05},
    '{24'h0A0A08, 24'h0A0A07, 24'h0A0A06, 24'h0A0A05, 24'h0A0A04, 24'h0A0A03, 24'h0A0A02, 24'h0A0A01},
    '{24'h280504, 24'h0A1400, 24'h141402, 24'h0A0201, 24'h1E0A00, 24'h000A03, 24'h050505, 24'h3F013F},
    '{24'h0A640A, 24'h0A3F0A, 24'h7F7F7F, 24'h0A3E0A, 24'h0A3E0A, 24'h0A3E0A, 24'h0A3E0A, 24'h0A3E0A},
    '{24'h000505, 24'h000505, 24'h000505, 24'h000000, 24'h000505, 24'h000505, 24'h01013F, 24'h000505},
    '{24'h0A0A05, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05},
    '{24'h0A0A04, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05, 24'h0A0A05}
  };
  localparam bit CARRY [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [N-1:0]       instr_pulse = '0, miss_pulse = '0, serv_pulse = '0;
  logic [N*IDW-1:0]   order_o;
  logic [IDW-1:0]     top_id_o;
  logic               done_o;

  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;
  int eff_i [N], eff_m [N], eff_s [N], exp_ord [N];

  always #2.5 clk = ~clk;

  dsr_thread_ranker #(.N_THREADS(N), .CNT_W(CW), .INTERVAL(INTV)) uut (
    .clk_i (clk), .rst_ni (rst_ni),
    .instr_pulse_i (instr_pulse), .miss_pulse_i (miss_pulse), .serv_pulse_i (serv_pulse),
    .order_o (order_o), .top_id_o (top_id_o), .done_o (done_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
    end
  endtask

  function automatic int sat(input int x);
    return (x > MAXC) ? MAXC : x;
  endfunction

  function automatic string vlabel(input int v);
    case (v)
      0: return "R4 tie";
      1: return "R3 service";
      2: return "R2 R3 R4 mix";
      3: return "R6 saturate";
      4: return "R2 zero instr";
      default: return "R5 boundary";
    endcase
  endfunction

  // true if thread a outranks thread b
  function automatic bit above(input int a, input int b);
    longint ma, ia, mb, ib, l, r;
    if (eff_s[a] == 0 && eff_s[b] == 0) return a < b;
    if (eff_s[a] == 0) return 1'b1;
    if (eff_s[b] == 0) return 1'b0;
    ma = (eff_i[a] == 0) ? 0 : eff_m[a];  ia = (eff_i[a] == 0) ? 1 : eff_i[a];
    mb = (eff_i[b] == 0) ? 0 : eff_m[b];  ib = (eff_i[b] == 0) ? 1 : eff_i[b];
    l = ma * ib * eff_s[b];
    r = mb * ia * eff_s[a];
    if (l != r) return l > r;
    return a < b;
  endfunction

  task automatic build_exp(input int v);
    bit used [N];
    for (int t = 0; t < N; t++) begin
      eff_i[t] = sat(int'(VEC[v][t][23:16]));
      eff_m[t] = sat(int'(VEC[v][t][15:8]));
      eff_s[t] = sat(int'(VEC[v][t][7:0]));
      used[t]  = 1'b0;
    end
    if (v > 0 && CARRY[v-1]) eff_s[0] = sat(eff_s[0] + 1);
    for (int k = 0; k < N; k++) begin
      int best = -1;
      for (int t = 0; t < N; t++)
        if (!used[t] && (best < 0 || above(t, best))) best = t;
      exp_ord[k] = best;
      used[best] = 1'b1;
    end
  endtask

  function automatic int slot(input int k);
    return int'(order_o[k*IDW +: IDW]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL R7 watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N*IDW-1:0] prev_ord;
    bit stab;
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int k = 0; k < N; k++) check(slot(k) == k, "R9", "reset slot", slot(k), k);
    check(top_id_o == 0, "R9", "reset top", int'(top_id_o), 0);
    check(done_o == 1'b0, "R9", "reset done", int'(done_o), 0);
    rst_ni = 1'b1;
    prev_ord = order_o;

    for (int v = 0; v <= NV; v++) begin
      stab = 1'b1;
      if (v > 0) build_exp(v - 1);
      for (int c = 0; c < INTV; c++) begin
        if (!done_o && order_o != prev_ord) stab = 1'b0;
        prev_ord = order_o;
        if (v > 0 && (c == N - 1 || c == N || c == N + 1))
          check(done_o == (c == N), "R7", "done timing (R1 window)", int'(done_o), int'(c == N));
        if (v > 0 && c == N) begin
          for (int k = 0; k < N; k++)
            check(slot(k) == exp_ord[k], vlabel(v - 1), $sformatf("slot %0d", k), slot(k), exp_ord[k]);
          check(int'(top_id_o) == exp_ord[0], "R8", "top id", int'(top_id_o), exp_ord[0]);
        end
        if (v > 0 && c == INTV - 1) begin
          check(stab, "R8", "hold between strobes", int'(stab), 1);
          check(int'(top_id_o) == exp_ord[0], "R8", "top held", int'(top_id_o), exp_ord[0]);
        end
        for (int t = 0; t < N; t++) begin
          instr_pulse[t] = (v < NV) && (c < int'(VEC[(v < NV) ? v : 0][t][23:16]));
          miss_pulse[t]  = (v < NV) && (c < int'(VEC[(v < NV) ? v : 0][t][15:8]));
          serv_pulse[t]  = (v < NV) && (c < int'(VEC[(v < NV) ? v : 0][t][7:0]));
        end
        if (v < NV && CARRY[v] && c == INTV - 1) serv_pulse[0] = 1'b1;
        @(negedge clk);
      end
    end

    instr_pulse = '0; miss_pulse = '0; serv_pulse = '0;
    rst_ni = 1'b0;
    @(negedge clk);
    for (int k = 0; k < N; k++) check(slot(k) == k, "R9", "re-reset slot", slot(k), k);
    check(done_o == 1'b0, "R9", "re-reset done", int'(done_o), 0);

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule